// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block receives configuration over a write-only three-wire bus made up of an active-low select, a serial clock and a data line. Up to 64 devices can hang on the same wires. Each device has a 6-bit strap address, and it only listens to transfers whose leading command byte carries that address. The command byte also names one of two channels, X or Y. The next byte replaces that channel's control register. An optional third byte sets the channel's input time slot and an optional fourth byte sets its output time slot.

The three bus wires are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the serial clock is edge-detected in the system clock domain. A byte counts only once all eight of its bits have arrived. Raising the select line ends the transfer and throws away any partial byte.

While a matched transfer is in progress, the `updating` output is high. The surrounding chip uses it to float its data outputs. Every register write produces a one-cycle `update_done` strobe for the written channel. That strobe has no acceptance handshake, so a consumer must take it in the cycle it appears. The processing core clears a channel's algorithm-reset bit by pulsing the matching `alg_reset_done` input.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, both control registers read 0x20 (only the idle bit, bit 5, set). All four slot registers read 0, and `updating` and `update_done` are low.
- R2: Data is sampled on rising serial-clock edges while select is low, least significant bit first. In the command byte, bits 5..0 hold the address, bit 6 picks the channel (1 = X, 0 = Y) and bit 7 must be 0. On a match, the second byte is stored whole in the picked channel's control register.
- R3: If the command byte's address differs from `strap_addr`, or its bit 7 is 1, the rest of the transfer changes no register. It also raises neither `updating` nor `update_done`.
- R4: In a matched transfer, bits 5..0 of the third byte load the picked channel's input slot and bits 5..0 of the fourth byte load its output slot. Bits 7..6 of both bytes are dropped.
- R5: A transfer with only two bytes leaves both slot registers unchanged. No transfer alters the channel it did not pick.
- R6: A byte that has fewer than eight bits when select rises is discarded and writes nothing.
- R7: Bytes after the fourth in one transfer are ignored.
- R8: A one-cycle pulse on `alg_reset_done[c]` (index 1 = X, 0 = Y) clears bit 4 of that channel's control register on the next cycle. It leaves the other bits and the other channel untouched.
- R9: `updating` goes high once a matching command byte completes. It stays high until the synchronized select is seen high, and otherwise it is low.
- R10: `update_done[c]` pulses for exactly one cycle for each register written in channel c (index 1 = X, 0 = Y). A 4-byte transfer gives three pulses and a 2-byte transfer gives one.
- R11: Serial-clock edges while select is high have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 6 | Device address this instance answers to |
| spi_cs_n | input | 1 | Bus select, active low, asynchronous |
| spi_sclk | input | 1 | Bus serial clock, asynchronous |
| spi_sdi | input | 1 | Bus serial data, least significant bit first |
| alg_reset_done | input | 2 | Core signals algorithm reset finished (bit 1 = X, bit 0 = Y) |
| ctrl_x | output | 8 | Channel X control register |
| in_slot_x | output | 6 | Channel X input time slot |
| out_slot_x | output | 6 | Channel X output time slot |
| ctrl_y | output | 8 | Channel Y control register |
| in_slot_y | output | 6 | Channel Y input time slot |
| out_slot_y | output | 6 | Channel Y output time slot |
| updating | output | 1 | High while a matched transfer is in progress |
| update_done | output | 2 | One-cycle strobe per register write (bit 1 = X, bit 0 = Y) |

## Verification
The properties rely on three assumptions about the bus:
- Each serial-clock level lasts at least three system clocks, so every edge survives the synchronizer.
- The data line is steady around each rising edge.
- The select line stays low for a few clocks after the last edge.

The properties also assume that `alg_reset_done` is only pulsed while no transfer is updating the same channel. The stimulus holds each clock level for four cycles and changes data only while the serial clock is low. It waits six cycles before raising select and issues reset-done pulses only between transfers.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 6;
  localparam int SLOT_W    = 6;
  localparam int NUM_CH    = 2;
  localparam int MAX_BYTES = 4;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int IDX_W     = $clog2(MAX_BYTES + 1);
  localparam int CH_X      = 1;
  localparam int CH_Y      = 0;

  // Field order is fixed: the processing core decodes these positions.
  typedef struct packed {
    logic as0;
    logic as1;
    logic idle;
    logic alg_rst;
    logic bypass;
    logic mu_law;
    logic as2;
    logic compress;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{as0: 1'b0, as1: 1'b0, idle: 1'b1, alg_rst: 1'b0,
                                   bypass: 1'b0, mu_law: 1'b0, as2: 1'b0, compress: 1'b0};

  // Position of a byte within one transfer.
  typedef enum logic [IDX_W-1:0] {
    POS_CMD   = 3'd0,
    POS_CTRL  = 3'd1,
    POS_ISLOT = 3'd2,
    POS_OSLOT = 3'd3
  } byte_pos_e;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgp_shifter.sv
module cfgp_shifter #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter int IDX_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data,
  output logic [IDX_W-1:0]  byte_num
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(MAX_BYTES);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  idx;
  logic              last_bit;

  assign last_bit  = (bit_cnt == LAST_BIT);
  assign byte_data = {bit_in, shreg[BYTE_W-1:1]};
  assign byte_num  = idx;
  assign byte_stb  = frame_active & bit_stb & last_bit & (idx != IDX_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      idx     <= '0;
    end else if (!frame_active) begin
      bit_cnt <= '0;
      idx     <= '0;
    end else if (bit_stb) begin
      shreg <= {bit_in, shreg[BYTE_W-1:1]};
      if (last_bit) begin
        bit_cnt <= '0;
        if (idx != IDX_FULL) idx <= idx + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgp_frame_dec.sv
module cfgp_frame_dec
  import cfgp_pkg::*;
#(
  parameter int BYTE_W = cfgp_pkg::BYTE_W,
  parameter int ADDR_W = cfgp_pkg::ADDR_W,
  parameter int CH_W   = cfgp_pkg::CH_W,
  parameter int IDX_W  = cfgp_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [IDX_W-1:0]  byte_num,
  output logic              wr_ctrl,
  output logic              wr_islot,
  output logic              wr_oslot,
  output logic [CH_W-1:0]   wr_ch,
  output logic              updating
);
  localparam int RSV_LO = ADDR_W + CH_W;

  logic            matched;
  logic [CH_W-1:0] sel_ch;
  logic            addr_hit;
  logic            rsv_clear;
  logic            hit;

  assign addr_hit  = (byte_data[ADDR_W-1:0] == strap_addr);
  assign rsv_clear = ~|byte_data[BYTE_W-1:RSV_LO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      matched <= 1'b0;
      sel_ch  <= '0;
    end else if (!frame_active) begin
      matched <= 1'b0;
    end else if (byte_stb && byte_num == POS_CMD) begin
      matched <= addr_hit & rsv_clear;
      sel_ch  <= byte_data[ADDR_W +: CH_W];
    end
  end

  assign hit      = byte_stb & matched;
  assign wr_ctrl  = hit & (byte_num == POS_CTRL);
  assign wr_islot = hit & (byte_num == POS_ISLOT);
  assign wr_oslot = hit & (byte_num == POS_OSLOT);
  assign wr_ch    = sel_ch;
  assign updating = matched;
endmodule

// File: rtl/cfgp_chan_regs.sv
module cfgp_chan_regs
  import cfgp_pkg::*;
#(
  parameter int BYTE_W = cfgp_pkg::BYTE_W,
  parameter int SLOT_W = cfgp_pkg::SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_islot,
  input  logic              wr_oslot,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              alg_done,
  output logic [BYTE_W-1:0] ctrl,
  output logic [SLOT_W-1:0] in_slot,
  output logic [SLOT_W-1:0] out_slot,
  output logic              done
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RESET;
      in_slot  <= '0;
      out_slot <= '0;
      done     <= 1'b0;
    end else begin
      done <= wr_ctrl | wr_islot | wr_oslot;
      if (wr_ctrl)       ctrl_q         <= ctrl_t'(wr_data);
      else if (alg_done) ctrl_q.alg_rst <= 1'b0;
      if (wr_islot) in_slot  <= wr_data[SLOT_W-1:0];
      if (wr_oslot) out_slot <= wr_data[SLOT_W-1:0];
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfgp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  input  logic [NUM_CH-1:0] alg_reset_done,
  output logic [BYTE_W-1:0] ctrl_x,
  output logic [SLOT_W-1:0] in_slot_x,
  output logic [SLOT_W-1:0] out_slot_x,
  output logic [BYTE_W-1:0] ctrl_y,
  output logic [SLOT_W-1:0] in_slot_y,
  output logic [SLOT_W-1:0] out_slot_y,
  output logic              updating,
  output logic [NUM_CH-1:0] update_done
);
  logic cs_s, sclk_s, sdi_s, sclk_q;
  logic frame_active, bit_stb;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_data;
  logic [IDX_W-1:0]  byte_num;
  logic              wr_ctrl, wr_islot, wr_oslot;
  logic [CH_W-1:0]   wr_ch;

  logic [BYTE_W-1:0] ctrl_arr [NUM_CH];
  logic [SLOT_W-1:0] islot_arr[NUM_CH];
  logic [SLOT_W-1:0] oslot_arr[NUM_CH];

  cfgp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(spi_cs_n), .q(cs_s));
  cfgp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(spi_sclk), .q(sclk_s));
  cfgp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .d(spi_sdi), .q(sdi_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign frame_active = ~cs_s;
  assign bit_stb      = frame_active & sclk_s & ~sclk_q;

  cfgp_shifter #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active),
    .bit_stb(bit_stb), .bit_in(sdi_s),
    .byte_stb(byte_stb), .byte_data(byte_data), .byte_num(byte_num));

  cfgp_frame_dec #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CH_W(CH_W), .IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .frame_active(frame_active), .strap_addr(strap_addr),
    .byte_stb(byte_stb), .byte_data(byte_data), .byte_num(byte_num),
    .wr_ctrl(wr_ctrl), .wr_islot(wr_islot), .wr_oslot(wr_oslot),
    .wr_ch(wr_ch), .updating(updating));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic sel;
    assign sel = (wr_ch == CH_W'(ch));
    cfgp_chan_regs #(.BYTE_W(BYTE_W), .SLOT_W(SLOT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_ctrl(wr_ctrl & sel), .wr_islot(wr_islot & sel), .wr_oslot(wr_oslot & sel),
      .wr_data(byte_data), .alg_done(alg_reset_done[ch]),
      .ctrl(ctrl_arr[ch]), .in_slot(islot_arr[ch]), .out_slot(oslot_arr[ch]),
      .done(update_done[ch]));
  end

  assign ctrl_x     = ctrl_arr[CH_X];
  assign in_slot_x  = islot_arr[CH_X];
  assign out_slot_x = oslot_arr[CH_X];
  assign ctrl_y     = ctrl_arr[CH_Y];
  assign in_slot_y  = islot_arr[CH_Y];
  assign out_slot_y = oslot_arr[CH_Y];
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int BYTE_W = 8,
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic [1:0]        alg_reset_done,
  input logic              updating,
  input logic [1:0]        update_done,
  input logic [BYTE_W-1:0] ctrl_x,
  input logic [BYTE_W-1:0] ctrl_y,
  input logic [SLOT_W-1:0] in_slot_x,
  input logic [SLOT_W-1:0] out_slot_x
);
  AST_DONE_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(update_done)); // R10

  AST_DONE_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (|update_done) |-> updating); // R9

  AST_CTRL_X_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ctrl_x[7:5], ctrl_x[3:0]}) |-> update_done[1]); // R3

  AST_CTRL_Y_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ctrl_y[7:5], ctrl_y[3:0]}) |-> update_done[0]); // R5

  AST_SLOT_X_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({in_slot_x, out_slot_x}) |-> update_done[1]); // R4

  AST_ALG_CLEAR_X: assert property (@(posedge clk) disable iff (!rst_n)
    (alg_reset_done[1] && !updating) |=> !ctrl_x[4]); // R8

  AST_ALG_CLEAR_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (alg_reset_done[0] && !updating) |=> !ctrl_y[4]); // R8

  AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |=> !updating); // R9
endmodule

bind cfg_serial_port cfgp_checker #(.BYTE_W(8), .SLOT_W(6)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .alg_reset_done(alg_reset_done),
  .updating(updating), .update_done(update_done), .ctrl_x(ctrl_x), .ctrl_y(ctrl_y),
  .in_slot_x(in_slot_x), .out_slot_x(out_slot_x));

// File: tb/cfg_serial_port_test.sv
module cfg_serial_port_test;
  localparam logic [5:0] STRAP = 6'h2B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_sdi = 1'b0;
  logic [1:0] alg_reset_done = 2'b00;
  logic [7:0] ctrl_x, ctrl_y;
  logic [5:0] in_slot_x, out_slot_x, in_slot_y, out_slot_y;
  logic       updating;
  logic [1:0] update_done;

  int checks = 0, errors = 0;
  int done_cnt [2] = '{0, 0};
  logic [7:0] e_ctrl [2];
  logic [5:0] e_in [2];
  logic [5:0] e_out [2];
  int e_done [2];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_serial_port uut (
    .clk(clk), .rst_n(rst_n), .strap_addr(STRAP), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_sdi(spi_sdi), .alg_reset_done(alg_reset_done),
    .ctrl_x(ctrl_x), .in_slot_x(in_slot_x), .out_slot_x(out_slot_x),
    .ctrl_y(ctrl_y), .in_slot_y(in_slot_y), .out_slot_y(out_slot_y),
    .updating(updating), .update_done(update_done));

  always @(negedge clk) if (rst_n) begin
    if (update_done[1]) done_cnt[1] = done_cnt[1] + 1;
    if (update_done[0]) done_cnt[0] = done_cnt[0] + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit addr_ok(input logic [7:0] cmd);
    return (cmd[5:0] == STRAP) && !cmd[7];
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " ctrl_x"}, 32'(ctrl_x), 32'(e_ctrl[1]));
    chk({tag, " ctrl_y"}, 32'(ctrl_y), 32'(e_ctrl[0]));
    chk({tag, " in_slot_x"}, 32'(in_slot_x), 32'(e_in[1]));
    chk({tag, " in_slot_y"}, 32'(in_slot_y), 32'(e_in[0]));
    chk({tag, " out_slot_x"}, 32'(out_slot_x), 32'(e_out[1]));
    chk({tag, " out_slot_y"}, 32'(out_slot_y), 32'(e_out[0]));
    chk({tag, " R10 done_x"}, 32'(done_cnt[1]), 32'(e_done[1]));
    chk({tag, " R10 done_y"}, 32'(done_cnt[0]), 32'(e_done[0]));
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      spi_sdi = b[i];
      repeat (4) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (4) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic do_frame(input logic [7:0] cmd, input logic [7:0] c, input logic [7:0] ti,
                          input logic [7:0] to, input logic [7:0] xb, input int nb,
                          input int part, input string tag);
    logic [7:0] b [5];
    bit m;
    int ch;
    b[0] = cmd; b[1] = c; b[2] = ti; b[3] = to; b[4] = xb;
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < nb; k++) send_bits(b[k], 8);
    if (part > 0 && nb < 5) send_bits(b[nb], part);
    repeat (6) @(negedge clk);
    m = addr_ok(cmd) && nb >= 1;
    chk({tag, " R9 updating in frame"}, 32'(updating), 32'(m));
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
    chk({tag, " R9 updating after frame"}, 32'(updating), 32'd0);
    if (m) begin
      ch = int'(cmd[6]);
      if (nb >= 2) e_ctrl[ch] = c;
      if (nb >= 3) e_in[ch] = ti[5:0];
      if (nb >= 4) e_out[ch] = to[5:0];
      e_done[ch] += ((nb > 4) ? 4 : nb) - 1;
    end
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    e_ctrl[0] = 8'h20; e_ctrl[1] = 8'h20;
    e_in[0] = '0; e_in[1] = '0; e_out[0] = '0; e_out[1] = '0;
    e_done[0] = 0; e_done[1] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 updating", 32'(updating), 32'd0);
    chk("R1 update_done", 32'(update_done), 32'd0);
    check_all("R1 reset");

    do_frame({2'b01, STRAP}, 8'h9D, 8'h00, 8'h00, 8'h00, 2, 0, "R2 R5 two-byte X");
    do_frame({2'b00, STRAP}, 8'h47, 8'hC5, 8'h7F, 8'h00, 4, 0, "R4 four-byte Y");
    do_frame({2'b01, STRAP ^ 6'h01}, 8'hFF, 8'h11, 8'h22, 8'h00, 4, 0, "R3 wrong address");
    do_frame({2'b11, STRAP}, 8'h00, 8'h33, 8'h33, 8'h00, 4, 0, "R3 reserved bit set");
    do_frame({2'b01, STRAP}, 8'h12, 8'h2A, 8'h00, 8'h00, 2, 5, "R6 partial byte");
    do_frame({2'b01, STRAP}, 8'h55, 8'h19, 8'h0E, 8'hAA, 5, 0, "R7 fifth byte");
    do_frame({2'b00, STRAP}, 8'hBB, 8'h00, 8'h00, 8'h00, 2, 0, "R5 two-byte Y slots kept");

    // R11: serial clock toggles with select high
    for (int i = 0; i < 24; i++) begin
      spi_sdi = 1'($urandom);
      repeat (4) @(negedge clk);
      spi_sclk = ~spi_sclk;
    end
    spi_sclk = 1'b0;
    repeat (8) @(negedge clk);
    check_all("R11 deselected clocking");

    // R8: set algorithm-reset bit in both channels, clear only X
    do_frame({2'b01, STRAP}, 8'h10, 8'h00, 8'h00, 8'h00, 2, 0, "R8 setup X");
    do_frame({2'b00, STRAP}, 8'h93, 8'h00, 8'h00, 8'h00, 2, 0, "R8 setup Y");
    alg_reset_done = 2'b10;
    @(negedge clk);
    alg_reset_done = 2'b00;
    @(negedge clk);
    e_ctrl[1] = 8'h00;
    check_all("R8 clear X only");
    alg_reset_done = 2'b01;
    @(negedge clk);
    alg_reset_done = 2'b00;
    @(negedge clk);
    e_ctrl[0] = 8'h83;
    check_all("R8 clear Y");

    for (int n = 0; n < 40; n++) begin
      logic [7:0] cmd;
      int nb, part, sel;
      cmd[5:0] = ($urandom % 4 == 0) ? 6'($urandom) : STRAP;
      cmd[6]   = 1'($urandom);
      cmd[7]   = ($urandom % 8 == 0);
      sel = $urandom % 8;
      nb  = (sel < 3) ? 2 : (sel < 6) ? 4 : (sel == 6) ? 3 : 5;
      part = ($urandom % 5 == 0 && nb < 5) ? 1 + ($urandom % 7) : 0;
      do_frame(cmd, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), nb, part,
               "R2 R4 R5 R6 R7 random");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule